// File: doc/BRIEF.md
# Parallel Port Register File

This block is the processor side of a 24-line parallel I/O interface. A host reaches it through an 8-bit bus with a select, a read strobe, a write strobe and a 2-bit register address. Behind that bus sit three ports: port A (8 lines), port B (8 lines), and port C. Port C is split into an upper and a lower half of 4 lines each. Each port, and each half of port C, is set to input or output for plain, handshake-free I/O.

A single control address takes two kinds of write, told apart by bit 7. A mode word sets every direction at once and clears the output latches. A bit command sets or clears one port C line. Output ports hold what the host wrote, and the block drives that value on the pins together with an enable. Input ports are not latched: a read returns the pins as they are during the read. The bidirectional system data bus is modelled as a write bus, a read bus and a read-enable.

Top module: `pio_regfile`

## Requirements
- R1: Writes and reads with `bus_sel` and the strobe high select by `bus_addr`: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. A write takes effect at the rising clock edge where it is sampled.
- R2: A control write with bit 7 = 1 is a mode word. Bit 4 gives the port A direction, bit 3 the port C upper direction, bit 1 the port B direction and bit 0 the port C lower direction, with 1 meaning input. The pin enables (`pa_oe`, `pb_oe`, `pc_oe[7:4]`, `pc_oe[3:0]`) are high exactly for the outputs.
- R3: Mode word 0x91 gives port A input, port B output, port C upper output and port C lower input.
- R4: Mode word 0x83 gives port A output, port B input, port C upper output and port C lower input.
- R5: Every mode word clears all output latches (A, B and C) to zero.
- R6: A write to an output port or output half is latched and driven on its `*_drv` pins from the next cycle. A read of that port or half returns the latched value.
- R7: A read of an input port or input half returns the live pin values during the read, with no latching. A port C read mixes the halves, each according to its own direction.
- R8: A write to an input port, or to the input half of port C, leaves that latch unchanged.
- R9: A control write with bit 7 = 0 is a bit command: bits 3:1 give the port C bit index and bit 0 gives the new value (1 sets, 0 clears). When that bit lies in an output half, only that latch bit changes. Directions are untouched.
- R10: A bit command aimed at a bit in an input half of port C changes nothing.
- R11: The group mode fields (bits 6:5 and bit 2 of a mode word) do not change direction or data behaviour. They are kept only for read-back.
- R12: A synchronous active-low reset makes all ports inputs (all enables low) and clears all latches. The control read-back value after reset is 0x9B.
- R13: `bus_rdata_oe` is high only while `bus_sel` and `bus_rd` are both high, and `bus_rdata` is 0 otherwise. A control register read returns the stored mode word with bit 7 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Block select from the address decoder |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rdata_oe | output | 1 | Read data enable toward the shared bus |
| pa_pin | input | 8 | Port A pin levels |
| pa_drv | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_pin | input | 8 | Port B pin levels |
| pb_drv | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_pin | input | 8 | Port C pin levels |
| pc_drv | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-line drive enables |

## Verification
The hardest case to reach from the ports is port C with one half output and the other half input. A single read must then return latched bits in one nibble and live pin bits in the other, and bit commands must land only in the output half. The stimulus programs the mixed mode words 0x91 and 0x83 while holding port C pins at a pattern different from every written value. It then issues full writes and bit commands aimed at both halves, so any crossed half or missed gate shows up in the read-back nibble and on `pc_drv`.

// File: rtl/pio_pkg.sv
// Shared types for the parallel port register file.
// Assumes an 8-bit host bus; the configuration packs one direction flag
// per port or half plus the group mode fields kept for read-back.
package pio_pkg;

    typedef struct packed {
        logic       a_in;    // port A is input
        logic       b_in;    // port B is input
        logic       cu_in;   // port C upper half is input
        logic       cl_in;   // port C lower half is input
        logic [1:0] ga_mode; // group A mode field (read-back only)
        logic       gb_mode; // group B mode field (read-back only)
    } pio_cfg_t;

    localparam logic [1:0] ADDR_PA   = 2'd0;
    localparam logic [1:0] ADDR_PB   = 2'd1;
    localparam logic [1:0] ADDR_PC   = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    localparam pio_cfg_t CFG_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1,
                                       cl_in: 1'b1, ga_mode: 2'b00, gb_mode: 1'b0};

endpackage

// File: rtl/pio_ctrl.sv
// Control register decoder.
// Splits a control write into a mode word (bit 7 set) or a port C bit
// command (bit 7 clear) and holds the direction configuration.
// Assumes DATA_W = 8, so the bit index occupies bits IDX_W:1.
module pio_ctrl
    import pio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output pio_cfg_t          cfg,
    output logic              mode_load,
    output logic              bsr_en,
    output logic [IDX_W-1:0]  bsr_idx,
    output logic              bsr_val
);

    // Classify the control write by its top bit.
    always_comb begin
        mode_load = ctrl_wr &  wdata[DATA_W-1];
        bsr_en    = ctrl_wr & ~wdata[DATA_W-1];
        bsr_idx   = wdata[IDX_W:1];
        bsr_val   = wdata[0];
    end

    // Hold the configuration; only a mode word replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (mode_load) begin
            cfg.a_in    <= wdata[4];
            cfg.cu_in   <= wdata[3];
            cfg.b_in    <= wdata[1];
            cfg.cl_in   <= wdata[0];
            cfg.ga_mode <= wdata[6:5];
            cfg.gb_mode <= wdata[2];
        end
    end

endmodule

// File: rtl/pio_latch.sv
// Output latch with per-bit load mask and synchronous clear.
// Assumes clear and load are never meant to act together; clear wins.
module pio_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Update only the masked bits on a load; clear on reset or clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (ld) begin
            q <= (q & ~mask) | (d & mask);
        end
    end

endmodule

// File: rtl/pio_rdmux.sv
// Read data selector.
// Output ports read back their latch, input ports read the live pins,
// and the control address returns the stored mode word.
// Purely combinational; assumes pins are already synchronous to clk.
module pio_rdmux
    import pio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  pio_cfg_t          cfg,
    input  logic [DATA_W-1:0] pa_q,
    input  logic [DATA_W-1:0] pb_q,
    input  logic [DATA_W-1:0] pc_q,
    input  logic [DATA_W-1:0] pa_pin,
    input  logic [DATA_W-1:0] pb_pin,
    input  logic [DATA_W-1:0] pc_pin,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    // Pick the read source for the addressed register.
    always_comb begin
        rdata    = '0;
        rdata_oe = rd_en;
        if (rd_en) begin
            case (addr)
                ADDR_PA: rdata = cfg.a_in ? pa_pin : pa_q;
                ADDR_PB: rdata = cfg.b_in ? pb_pin : pb_q;
                ADDR_PC: rdata = {cfg.cu_in ? pc_pin[DATA_W-1:HALF_W] : pc_q[DATA_W-1:HALF_W],
                                  cfg.cl_in ? pc_pin[HALF_W-1:0]      : pc_q[HALF_W-1:0]};
                default: rdata = {1'b1, cfg.ga_mode, cfg.a_in, cfg.cu_in,
                                  cfg.gb_mode, cfg.b_in, cfg.cl_in};
            endcase
        end
    end

endmodule

// File: rtl/pio_regfile.sv
// Parallel port register file (top).
// Decodes host accesses, owns the three port latches and drives the
// per-port enables from the direction configuration.
// Assumes a synchronous host bus sampled on the rising clock edge.
module pio_regfile
    import pio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    input  logic [DATA_W-1:0] pa_pin,
    output logic [DATA_W-1:0] pa_drv,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pb_pin,
    output logic [DATA_W-1:0] pb_drv,
    output logic              pb_oe,
    input  logic [DATA_W-1:0] pc_pin,
    output logic [DATA_W-1:0] pc_drv,
    output logic [DATA_W-1:0] pc_oe
);

    pio_cfg_t          cfg;
    logic              wr_hit, wr_a, wr_b, wr_c, wr_ctrl;
    logic              mode_load, bsr_en, bsr_val;
    logic [IDX_W-1:0]  bsr_idx;
    logic [DATA_W-1:0] bsr_onehot;

    // Decode the addressed write target.
    always_comb begin
        wr_hit  = bus_sel & bus_wr;
        wr_a    = wr_hit & (bus_addr == ADDR_PA);
        wr_b    = wr_hit & (bus_addr == ADDR_PB);
        wr_c    = wr_hit & (bus_addr == ADDR_PC);
        wr_ctrl = wr_hit & (bus_addr == ADDR_CTRL);
    end

    pio_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_ctrl),
        .wdata     (bus_wdata),
        .cfg       (cfg),
        .mode_load (mode_load),
        .bsr_en    (bsr_en),
        .bsr_idx   (bsr_idx),
        .bsr_val   (bsr_val)
    );

    assign bsr_onehot = {{(DATA_W-1){1'b0}}, 1'b1} << bsr_idx;

    pio_latch #(.W(DATA_W)) u_pa (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_load),
        .ld    (wr_a & ~cfg.a_in),
        .mask  ({DATA_W{1'b1}}),
        .d     (bus_wdata),
        .q     (pa_drv)
    );

    pio_latch #(.W(DATA_W)) u_pb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_load),
        .ld    (wr_b & ~cfg.b_in),
        .mask  ({DATA_W{1'b1}}),
        .d     (bus_wdata),
        .q     (pb_drv)
    );

    assign pa_oe = ~cfg.a_in;
    assign pb_oe = ~cfg.b_in;

    // One latch per port C half; each half is gated by its own direction.
    for (genvar h = 0; h < 2; h++) begin : g_pc_half
        localparam int LO = h * HALF_W;
        logic              half_out;
        logic [HALF_W-1:0] half_mask;
        logic [HALF_W-1:0] half_d;

        assign half_out  = (h == 1) ? ~cfg.cu_in : ~cfg.cl_in;
        assign half_mask = wr_c   ? {HALF_W{1'b1}}
                         : bsr_en ? bsr_onehot[LO +: HALF_W]
                         :          {HALF_W{1'b0}};
        assign half_d    = wr_c ? bus_wdata[LO +: HALF_W] : {HALF_W{bsr_val}};

        pio_latch #(.W(HALF_W)) u_pc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (mode_load),
            .ld    (half_out & (wr_c | bsr_en)),
            .mask  (half_mask),
            .d     (half_d),
            .q     (pc_drv[LO +: HALF_W])
        );

        assign pc_oe[LO +: HALF_W] = {HALF_W{half_out}};
    end

    pio_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .rd_en    (bus_sel & bus_rd),
        .addr     (bus_addr),
        .cfg      (cfg),
        .pa_q     (pa_drv),
        .pb_q     (pb_drv),
        .pc_q     (pc_drv),
        .pa_pin   (pa_pin),
        .pb_pin   (pb_pin),
        .pc_pin   (pc_pin),
        .rdata    (bus_rdata),
        .rdata_oe (bus_rdata_oe)
    );

endmodule

// File: rtl/pio_regfile_chk.sv
// Property checker for pio_regfile, attached by bind below.
// Observes ports only; assumes the default 8-bit width.
module pio_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       bus_rdata_oe,
    input logic [7:0] pa_pin,
    input logic [7:0] pa_drv,
    input logic       pa_oe,
    input logic [7:0] pb_pin,
    input logic [7:0] pb_drv,
    input logic       pb_oe,
    input logic [7:0] pc_pin,
    input logic [7:0] pc_drv,
    input logic [7:0] pc_oe
);

    // R12
    reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!pa_oe && !pb_oe && pc_oe == 8'h00 &&
                           pa_drv == 8'h00 && pb_drv == 8'h00 && pc_drv == 8'h00));

    // R5
    mode_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd3 && bus_wdata[7])
        |=> (pa_drv == 8'h00 && pb_drv == 8'h00 && pc_drv == 8'h00));

    // R6
    out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd0 && pa_oe) |=> pa_drv == $past(bus_wdata));

    // R8
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1 && !pb_oe) |=> $stable(pb_drv));

    // R9
    bit_cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd3 && !bus_wdata[7])
        |=> ($countones(pc_drv ^ $past(pc_drv)) <= 1 && $stable(pc_oe)));

    // R7
    in_read_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr == 2'd0 && !pa_oe) |-> bus_rdata == pa_pin);

    // R13
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (!bus_rdata_oe && bus_rdata == 8'h00));

endmodule

bind pio_regfile pio_regfile_chk u_chk (.*);

// File: tb/tb_pio_regfile.sv
module tb_pio_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_rdata_oe;
    logic [7:0] pa_pin = 8'h5A, pb_pin = 8'hC3, pc_pin = 8'h96;
    logic [7:0] pa_drv, pb_drv, pc_drv, pc_oe;
    logic       pa_oe, pb_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pio_regfile dut (.*);

    // Vector: {rd, addr[1:0], data[7:0], exp_oe, exp[7:0]}; pins 5A/C3/96.
    localparam int NV = 22;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 2'd3, 8'h91, 1'b0, 8'h00},  // R3 mode
        {1'b1, 2'd3, 8'h00, 1'b1, 8'h91},  // R13 read-back
        {1'b1, 2'd0, 8'h00, 1'b1, 8'h5A},  // R7 A input
        {1'b0, 2'd1, 8'hA5, 1'b0, 8'h00},
        {1'b1, 2'd1, 8'h00, 1'b1, 8'hA5},  // R6 B output
        {1'b0, 2'd2, 8'hFF, 1'b0, 8'h00},
        {1'b1, 2'd2, 8'h00, 1'b1, 8'hF6},  // R7 mixed halves
        {1'b0, 2'd0, 8'h77, 1'b0, 8'h00},
        {1'b1, 2'd0, 8'h00, 1'b1, 8'h5A},  // R8
        {1'b0, 2'd3, 8'h06, 1'b0, 8'h00},  // R10 bit 3 clear, input half
        {1'b1, 2'd2, 8'h00, 1'b1, 8'hF6},
        {1'b0, 2'd3, 8'h0C, 1'b0, 8'h00},  // R9 clear bit 6
        {1'b1, 2'd2, 8'h00, 1'b1, 8'hB6},
        {1'b0, 2'd3, 8'h83, 1'b0, 8'h00},  // R4, R5
        {1'b1, 2'd0, 8'h00, 1'b1, 8'h00},
        {1'b1, 2'd2, 8'h00, 1'b1, 8'h06},
        {1'b0, 2'd3, 8'h0F, 1'b0, 8'h00},  // R9 set bit 7
        {1'b1, 2'd2, 8'h00, 1'b1, 8'h86},
        {1'b1, 2'd1, 8'h00, 1'b1, 8'hC3},
        {1'b0, 2'd3, 8'hE4, 1'b0, 8'h00},  // R11 all out, modes set
        {1'b0, 2'd2, 8'h3C, 1'b0, 8'h00},
        {1'b1, 2'd2, 8'h00, 1'b1, 8'h3C}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata; oe = bus_rdata_oe;
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=01 expected=00");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 oe", {pa_oe, pb_oe, 6'd0}, 8'h00);
        chk("R12 pc_oe", pc_oe, 8'h00);
        chk("R12 latches", pa_drv | pb_drv | pc_drv, 8'h00);
        do_rd(2'd3, d, oe);
        chk("R12 ctrl", d, 8'h9B);
        // R13 idle bus
        #1 chk("R13 idle", {bus_rdata_oe, 7'd0} | bus_rdata, 8'h00);

        // Table walk (R1 R6 R7 R8 R9 R10 R11 R13)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) begin
                do_rd(VEC[i][18:17], d, oe);
                chk($sformatf("R1 R7 vec %0d data", i), d, VEC[i][7:0]);
                chk($sformatf("R13 vec %0d oe", i), {7'd0, oe}, {7'd0, VEC[i][8]});
            end else begin
                do_wr(VEC[i][18:17], VEC[i][16:9]);
            end
        end
        // R11 all outputs despite mode fields
        chk("R11 enables", {pa_oe, pb_oe, 6'd0}, 8'hC0);
        chk("R11 pc_oe", pc_oe, 8'hFF);
        do_rd(2'd3, d, oe);
        chk("R11 ctrl", d, 8'hE4);

        // R3 directions
        do_wr(2'd3, 8'h91);
        chk("R3 enables", {pa_oe, pb_oe, 6'd0}, 8'h40);
        chk("R3 pc_oe", pc_oe, 8'hF0);
        // R2 R4 directions
        do_wr(2'd3, 8'h83);
        chk("R4 enables", {pa_oe, pb_oe, 6'd0}, 8'h80);
        chk("R2 pc_oe", pc_oe, 8'hF0);
        // R6 driven pins, read ignores pins
        do_wr(2'd0, 8'h3C);
        chk("R6 pa_drv", pa_drv, 8'h3C);
        pa_pin = 8'hE1;
        do_rd(2'd0, d, oe);
        chk("R6 read latch", d, 8'h3C);
        // R8 write to input B
        do_wr(2'd1, 8'h11);
        chk("R8 pb_drv", pb_drv, 8'h00);
        // R10 set bit 2 (lower, input)
        do_wr(2'd3, 8'h05);
        chk("R10 pc_drv", pc_drv, 8'h00);
        // R9 set bit 4 (upper, output)
        do_wr(2'd3, 8'h09);
        chk("R9 pc_drv", pc_drv, 8'h10);
        chk("R9 pc_oe", pc_oe, 8'hF0);
        // R5 mode word clears
        do_wr(2'd3, 8'h83);
        chk("R5 latches", pa_drv | pc_drv, 8'h00);
        // R7 live pins
        do_wr(2'd3, 8'h91);
        pa_pin = 8'h12;
        do_rd(2'd0, d, oe);
        chk("R7 live1", d, 8'h12);
        pa_pin = 8'h34;
        do_rd(2'd0, d, oe);
        chk("R7 live2", d, 8'h34);
        // R12 reset mid-run
        do_wr(2'd1, 8'hAA);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R12 pb_drv", pb_drv, 8'h00);
        chk("R12 pc_oe again", pc_oe, 8'h00);
        chk("R12 oe again", {pa_oe, pb_oe, 6'd0}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule